// File: doc/BRIEF.md
# Interrupt and Clock Status Register

This block keeps the status byte of a small 8-bit controller core. The byte shows which interrupt priority level the core is servicing and whether the crystal oscillator has finished warming up. It also shows, for each of two serial ports, whether a transmission or a reception is in progress. The core, the oscillator controller and the serial ports report events to the block as single-cycle strobes. Software sees the byte at status address C5h and cannot write any of its bits.

The same flags also gate a small clock-control register on the special-function-register write bus. While serial traffic is in progress and the guard bit is set, a write to the two clock-divide bits is dropped. A write that sets the crystal-select bit is refused until the oscillator reports that it is ready. All state is held in registers. Every output changes on the clock edge that follows the strobe or write that causes it. Reset is the power-on reset.

There is no data stream at this block's edge. Every pin is a plain control or status signal, so there is no handshake and no back-pressure.

Top module: `irq_clk_status`

## Requirements
- R1: After reset, `status_o` is 8'h10 (only the warm-up flag set), `clk_div_o` is 0, `div_guard_o` is 0 and `xtal_sel_o` is 0.
- R2: The high-priority flag (status bit 6) is set on the edge after `irq_hi_enter`. The low-priority flag (bit 5) is set on the edge after `irq_lo_enter`.
- R3: `irq_return` clears bit 6 if bit 6 is set, and otherwise clears bit 5. An entry strobe in the same cycle still sets its own flag.
- R4: The warm-up flag (bit 4) is cleared by `osc_restart` and set by `osc_ready`. When both strobes arrive in the same cycle, `osc_restart` wins.
- R5: Transmit activity of port p (bit 3 for port 1, bit 1 for port 0) is set by `tx_start[p]` and cleared by `tx_done[p]`. When both arrive in the same cycle, the clear wins.
- R6: Receive activity of port p (bit 2 for port 1, bit 0 for port 0) is set by `rx_start[p]` and cleared by `rx_done[p]`. When both arrive in the same cycle, the clear wins.
- R7: Status bit 7 always reads 0. A write to address C5h changes no output.
- R8: A write to the control address (default 8'h86) loads `clk_div_o` from data bits [1:0]. If `div_guard_o` is 1 and any activity bit is 1 before the write, the divide field keeps its old value.
- R9: The guard bit (data bit 2 of a control write) is loaded on every control write. The guard value held before that write is the one that decides the divide check.
- R10: Data bit 3 of a control write loads `xtal_sel_o`. A write of 1 is refused while the warm-up flag is 0. A write of 0 is always accepted.
- R11: A write to any address other than the control address leaves `clk_div_o`, `div_guard_o` and `xtal_sel_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| irq_hi_enter | input | 1 | Core starts a high-priority service |
| irq_lo_enter | input | 1 | Core starts a low-priority service |
| irq_return | input | 1 | Core executes a return from interrupt |
| osc_restart | input | 1 | Oscillator restarted (power-down exit or oscillator switched off) |
| osc_ready | input | 1 | Warm-up counter reports the oscillator stable |
| tx_start | input | 2 | Per-port transmit begins |
| tx_done | input | 2 | Per-port transmit-interrupt flag set by hardware |
| rx_start | input | 2 | Per-port receive begins |
| rx_done | input | 2 | Per-port receive-interrupt flag set by hardware |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| status_o | output | 8 | Status byte |
| clk_div_o | output | 2 | Accepted clock-divide value |
| div_guard_o | output | 1 | Accepted guard bit for divide changes |
| xtal_sel_o | output | 1 | Accepted crystal-select bit |

## Verification
The bench aims at the cycles where two events meet. A return from interrupt with both levels active must drop the high level only; a design that cleared both flags, or the low one first, unwinds nesting wrongly. A start and a done on the same port in the same cycle must leave the port idle, and a restart with a ready must leave the warm-up flag clear; reversing either priority leaves a stale flag set. The bench also sets the crystal select before warm-up, changes the divide during traffic with the guard on and off, and writes to the status address and to unrelated addresses. A design that decided the guard from the new write data, or that decoded the address loosely, would change the clock controls there.

// File: rtl/irq_clk_pkg.sv
package irq_clk_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_SER  = 2;
  localparam int unsigned DIV_W    = 2;
  localparam int unsigned DIV_LSB  = 0;
  localparam int unsigned GUARD_BIT = 2;
  localparam int unsigned XSEL_BIT = 3;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'hC5;
endpackage

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_enter,
  input  logic lo_enter,
  input  logic ret,
  output logic hip,
  output logic lip
);
  logic hip_clr, lip_clr;

  // the return unwinds the innermost (high) level first
  assign hip_clr = ret & hip;
  assign lip_clr = ret & ~hip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hip <= 1'b0;
      lip <= 1'b0;
    end else begin
      hip <= (hip & ~hip_clr) | hi_enter;
      lip <= (lip & ~lip_clr) | lo_enter;
    end
  end
endmodule

// File: rtl/osc_warm_track.sv
module osc_warm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ready,
  output logic warm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       warm <= 1'b1;
    else if (restart) warm <= 1'b0;
    else if (ready)   warm <= 1'b1;
  end
endmodule

// File: rtl/serial_activity.sv
module serial_activity #(
  parameter int unsigned PORTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] tx_set,
  input  logic [PORTS-1:0] tx_clr,
  input  logic [PORTS-1:0] rx_set,
  input  logic [PORTS-1:0] rx_clr,
  output logic [PORTS-1:0] tx_act,
  output logic [PORTS-1:0] rx_act,
  output logic             any_act
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_act[p] <= 1'b0;
        rx_act[p] <= 1'b0;
      end else begin
        tx_act[p] <= (tx_act[p] | tx_set[p]) & ~tx_clr[p];
        rx_act[p] <= (rx_act[p] | rx_set[p]) & ~rx_clr[p];
      end
    end
  end

  assign any_act = |{tx_act, rx_act};
endmodule

// File: rtl/clk_ctl_guard.sv
module clk_ctl_guard
  import irq_clk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              traffic,
  input  logic              warm,
  output logic [DIV_W-1:0]  div,
  output logic              guard,
  output logic              xsel
);
  logic hit, div_ok, xsel_ok;

  assign hit     = wr && (addr == CTRL_ADDR);
  assign div_ok  = !(guard && traffic);
  assign xsel_ok = warm || !wdata[XSEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      guard <= 1'b0;
      xsel  <= 1'b0;
    end else if (hit) begin
      guard <= wdata[GUARD_BIT];
      if (div_ok)  div  <= wdata[DIV_LSB +: DIV_W];
      if (xsel_ok) xsel <= wdata[XSEL_BIT];
    end
  end
endmodule

// File: rtl/irq_clk_status.sv
module irq_clk_status
  import irq_clk_pkg::*;
#(
  parameter logic [7:0] CTRL_ADDR = 8'h86
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_hi_enter,
  input  logic       irq_lo_enter,
  input  logic       irq_return,
  input  logic       osc_restart,
  input  logic       osc_ready,
  input  logic [1:0] tx_start,
  input  logic [1:0] tx_done,
  input  logic [1:0] rx_start,
  input  logic [1:0] rx_done,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] status_o,
  output logic [1:0] clk_div_o,
  output logic       div_guard_o,
  output logic       xtal_sel_o
);
  logic hip, lip, warm, traffic;
  logic [NUM_SER-1:0] tx_act, rx_act;

  irq_level_track u_lvl (
    .clk(clk), .rst_n(rst_n), .hi_enter(irq_hi_enter), .lo_enter(irq_lo_enter),
    .ret(irq_return), .hip(hip), .lip(lip)
  );

  osc_warm_track u_warm (
    .clk(clk), .rst_n(rst_n), .restart(osc_restart), .ready(osc_ready), .warm(warm)
  );

  serial_activity #(.PORTS(NUM_SER)) u_ser (
    .clk(clk), .rst_n(rst_n), .tx_set(tx_start), .tx_clr(tx_done),
    .rx_set(rx_start), .rx_clr(rx_done), .tx_act(tx_act), .rx_act(rx_act),
    .any_act(traffic)
  );

  clk_ctl_guard #(.CTRL_ADDR(CTRL_ADDR)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(sfr_wr), .addr(sfr_addr), .wdata(sfr_wdata),
    .traffic(traffic), .warm(warm), .div(clk_div_o), .guard(div_guard_o),
    .xsel(xtal_sel_o)
  );

  // status address is read-only: its writes reach no register
  assign status_o[7] = 1'b0;
  assign status_o[6] = hip;
  assign status_o[5] = lip;
  assign status_o[4] = warm;
  for (genvar p = 0; p < NUM_SER; p++) begin : g_stat
    assign status_o[2*p+1] = tx_act[p];
    assign status_o[2*p]   = rx_act[p];
  end
endmodule

// File: rtl/irq_clk_status_chk.sv
module irq_clk_status_chk #(
  parameter logic [7:0] CTRL_ADDR = 8'h86
) (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_hi_enter,
  input logic       irq_return,
  input logic       osc_restart,
  input logic [1:0] tx_done,
  input logic [1:0] rx_done,
  input logic       sfr_wr,
  input logic [7:0] sfr_addr,
  input logic [7:0] status_o,
  input logic [1:0] clk_div_o,
  input logic       div_guard_o,
  input logic       xtal_sel_o
);
  p_bit7_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] == 1'b0);

  p_return_high_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && status_o[6] && !irq_hi_enter) |=> !status_o[6]);

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    osc_restart |=> !status_o[4]);

  p_tx_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done[0] |=> !status_o[1]);

  p_rx_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done[1] |=> !status_o[2]);

  p_div_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == CTRL_ADDR && div_guard_o && (|status_o[3:0]))
      |=> $stable(clk_div_o));

  p_xtal_needs_warm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal_sel_o) |-> $past(status_o[4]));

  p_other_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sfr_wr && sfr_addr == CTRL_ADDR))
      |=> ($stable(clk_div_o) && $stable(div_guard_o) && $stable(xtal_sel_o)));
endmodule

bind irq_clk_status irq_clk_status_chk #(.CTRL_ADDR(CTRL_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_hi_enter(irq_hi_enter), .irq_return(irq_return),
  .osc_restart(osc_restart), .tx_done(tx_done), .rx_done(rx_done),
  .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .status_o(status_o),
  .clk_div_o(clk_div_o), .div_guard_o(div_guard_o), .xtal_sel_o(xtal_sel_o)
);

// File: tb/irq_clk_status_tb_top.sv
module irq_clk_status_tb_top;
  localparam logic [7:0] CTRL = 8'h86;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hi_en = 0, lo_en = 0, ret = 0, restart = 0, ready = 0;
  logic [1:0] txs = 0, txd = 0, rxs = 0, rxd = 0;
  logic wr = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] status;
  logic [1:0] div;
  logic guard, xsel;

  int checks = 0, errors = 0;

  // behavioural reference state
  bit m_hip, m_lip, m_warm, m_guard, m_xsel;
  bit m_tx[2], m_rx[2];
  int m_div;

  always #2 clk = ~clk;

  irq_clk_status #(.CTRL_ADDR(CTRL)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_hi_enter(hi_en), .irq_lo_enter(lo_en),
    .irq_return(ret), .osc_restart(restart), .osc_ready(ready),
    .tx_start(txs), .tx_done(txd), .rx_start(rxs), .rx_done(rxd),
    .sfr_wr(wr), .sfr_addr(addr), .sfr_wdata(wdata),
    .status_o(status), .clk_div_o(div), .div_guard_o(guard), .xtal_sel_o(xsel)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hip = 0; m_lip = 0; m_warm = 1; m_guard = 0; m_xsel = 0; m_div = 0;
      foreach (m_tx[p]) begin m_tx[p] = 0; m_rx[p] = 0; end
    end else begin
      bit busy;
      busy = m_tx[0] | m_tx[1] | m_rx[0] | m_rx[1];
      if (wr && addr == CTRL) begin
        if (!(m_guard && busy)) m_div = wdata[1:0];
        if (!(wdata[3] && !m_warm)) m_xsel = wdata[3];
        m_guard = wdata[2];
      end
      if (ret) begin if (m_hip) m_hip = 0; else m_lip = 0; end
      if (hi_en) m_hip = 1;
      if (lo_en) m_lip = 1;
      if (restart) m_warm = 0; else if (ready) m_warm = 1;
      for (int p = 0; p < 2; p++) begin
        if (txs[p]) m_tx[p] = 1;
        if (txd[p]) m_tx[p] = 0;
        if (rxs[p]) m_rx[p] = 1;
        if (rxd[p]) m_rx[p] = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R7 bit7", int'(status[7]), 0);
    chk("R2 R3 high level", int'(status[6]), int'(m_hip));
    chk("R2 R3 low level", int'(status[5]), int'(m_lip));
    chk("R4 warm", int'(status[4]), int'(m_warm));
    chk("R5 tx activity", int'({status[3], status[1]}), int'({m_tx[1], m_tx[0]}));
    chk("R6 rx activity", int'({status[2], status[0]}), int'({m_rx[1], m_rx[0]}));
    chk("R8 divide", int'(div), m_div);
    chk("R9 guard", int'(guard), int'(m_guard));
    chk("R10 xtal select", int'(xsel), int'(m_xsel));
  endtask

  task automatic idle();
    hi_en = 0; lo_en = 0; ret = 0; restart = 0; ready = 0;
    txs = 0; txd = 0; rxs = 0; rxd = 0; wr = 0; addr = 0; wdata = 0;
  endtask

  // one cycle: compare what the last edge produced, then drive the next one
  task automatic tick();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    tick(); wr = 1; addr = a; wdata = d;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 status", int'(status), 'h10);
    chk("R1 controls", int'({div, guard, xsel}), 0);
    rst_n = 1;

    // R8/R9: guard on, traffic, divide write dropped, guard taken from held value
    wr_reg(CTRL, 8'h04);
    tick(); txs = 2'b01;
    wr_reg(CTRL, 8'h07);
    wr_reg(CTRL, 8'h02);   // guard still 1 before this write -> divide kept
    wr_reg(CTRL, 8'h01);   // guard now 0 -> divide accepted
    tick(); txs = 2'b10; txd = 2'b10;   // R5 same-cycle clear wins
    tick(); txd = 2'b01;
    tick(); rxs = 2'b11;
    tick(); rxs = 2'b01; rxd = 2'b01;   // R6 clear wins
    tick(); rxd = 2'b10;
    wr_reg(CTRL, 8'h06);
    tick(); chk("R8 accepted when idle", int'(div), 2);

    // R10: crystal select before and after warm-up
    tick(); restart = 1; ready = 1;     // R4 restart wins
    wr_reg(CTRL, 8'h08);
    tick(); chk("R10 refused", int'(xsel), 0);
    ready = 1;
    wr_reg(CTRL, 8'h08);
    tick(); chk("R10 accepted", int'(xsel), 1);
    restart = 1;
    wr_reg(CTRL, 8'h00);                // R10 clearing allowed while cold

    // R2/R3: nesting
    tick(); lo_en = 1;
    tick(); hi_en = 1;
    tick(); ret = 1;
    tick(); chk("R3 high unwinds first", int'(status[6:5]), 1);
    ret = 1;
    tick(); ret = 1; hi_en = 1;

    // R7/R11: writes to status and unrelated addresses
    wr_reg(8'hC5, 8'hFF);
    wr_reg(8'h33, 8'hFF);
    tick(); chk("R11 controls kept", int'({div, guard, xsel}), 0);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      tick();
      hi_en = ($urandom_range(0, 9) == 0);
      lo_en = ($urandom_range(0, 9) == 0);
      ret = ($urandom_range(0, 6) == 0);
      restart = ($urandom_range(0, 19) == 0);
      ready = ($urandom_range(0, 7) == 0);
      txs = 2'($urandom_range(0, 3)); txd = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      rxs = 2'($urandom_range(0, 3)); rxd = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      wr = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 3))
        0: addr = 8'hC5;
        1, 2: addr = CTRL;
        default: addr = 8'($urandom_range(0, 255));
      endcase
      wdata = 8'($urandom_range(0, 255));
    end
    tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule